// File: doc/BRIEF.md
# T1 Robbed-Bit Signaling Inserter

This block writes per-channel signaling bits into an outgoing T1 byte stream. Each of the 24 channels has a four-bit signaling word holding the bits A, B, C and D. Software loads these words through a one-cycle write port. The block counts frames within the superframe. In the frames that carry signaling, it replaces the least significant bit of an eligible channel's PCM byte with the signaling bit that belongs to that frame.

Two superframe formats are supported. The short format has 12 frames and carries only A and B. The extended format has 24 frames and carries A, B, C and D. Signaling can be switched off for the whole link with a global enable, or for a single channel with its own clear-channel bit. A new signaling word only goes into service at the start of the next superframe, so one superframe never mixes old and new values. Every byte leaves the block exactly one clock after it enters, together with a matching valid flag.

Top module: `t1_rbs_inserter`

## Requirements
- R1: `out_valid` is asserted exactly one clock after each cycle with `in_valid` high, and is low otherwise. While reset is held, `out_valid` and `out_byte` are zero.
- R2: Bits 7 down to 1 of `out_byte` always equal bits 7 down to 1 of the input byte one cycle earlier. The robbed position is bit 0, which is the eighth bit in transmission order.
- R3: A byte with `in_frame_start` and `in_sf_start` both high is in frame 1. Any other frame start advances the frame number by one. After the last frame of the superframe the number returns to 1: after frame 12 in short mode (`cfg_esf`=0) and after frame 24 in extended mode (`cfg_esf`=1).
- R4: In both modes, bit 0 of the output takes word bit 3 (A) in frame 6 and word bit 2 (B) in frame 12.
- R5: In extended mode, bit 0 of the output takes word bit 1 (C) in frame 18 and word bit 0 (D) in frame 24.
- R6: In short mode, bits C and D are never inserted. The 13th frame start after a resync is frame 1 again, and the 18th is frame 6, which carries A.
- R7: With `cfg_rb_en` low, every byte passes through unchanged.
- R8: A channel whose `cfg_clear[ch]` bit is one passes its bytes through unchanged. Channel numbers of 24 and above are never modified.
- R9: A word written with `wr_en` to channel `wr_chan` (0 to 23) is used from the next frame 1 onward. Until then, the previous word stays in force. Writes to channel numbers of 24 and above have no effect.
- R10: Frames other than those named in R4 and R5 pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rb_en | input | 1 | Global robbed-bit enable |
| cfg_esf | input | 1 | 1 selects the 24-frame format, 0 the 12-frame format |
| cfg_clear | input | 24 | Per-channel clear-channel bits; bit i is channel i |
| wr_en | input | 1 | Signaling word write strobe |
| wr_chan | input | 5 | Channel index for the write (0 to 23) |
| wr_sig | input | 4 | Word to write: bit 3 A, bit 2 B, bit 1 C, bit 0 D |
| in_valid | input | 1 | Input byte valid |
| in_chan | input | 5 | Channel index of the input byte (0 to 23) |
| in_frame_start | input | 1 | Marks the first byte of a frame |
| in_sf_start | input | 1 | With `in_frame_start`, marks frame 1 of a superframe |
| in_byte | input | 8 | Input PCM byte, bit 7 sent first |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Output byte with signaling inserted |

## Verification
The assertions rely on the input side behaving sensibly:
- `in_frame_start` and `in_sf_start` are only sampled together with `in_valid`.
- The configuration inputs change only between frames.
- A resync lands on the first byte of a frame.

The directed stimulus stays within these limits:
- It sends whole frames of 24 bytes, channels 0 to 23 in order, with the frame marker on channel 0.
- It changes the mode, the enables and the clear mask only while no byte is valid.
- It performs register writes only in idle cycles between frames.

// File: rtl/t1_rbs_pkg.sv
package t1_rbs_pkg;
  localparam int SIG_W = 4;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_A    = 3'd1,
    SEL_B    = 3'd2,
    SEL_C    = 3'd3,
    SEL_D    = 3'd4
  } sig_sel_e;
endpackage

// File: rtl/t1_rbs_frame_ctr.sv
module t1_rbs_frame_ctr
  import t1_rbs_pkg::*;
#(
  parameter int SF_D4 = 12
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     esf_mode,
  input  logic     step,
  input  logic     resync,
  output sig_sel_e sel,
  output logic     sf_begin
);
  localparam int SF_ESF = 2 * SF_D4;
  localparam int FW     = $clog2(SF_ESF + 1);

  logic [FW-1:0] frame_q, frame_nxt, frame_cur, sf_len;

  always_comb begin
    sf_len = esf_mode ? FW'(SF_ESF) : FW'(SF_D4);
    if (resync) begin
      frame_nxt = FW'(1);
    end else if (frame_q >= sf_len) begin
      frame_nxt = FW'(1);
    end else begin
      frame_nxt = frame_q + FW'(1);
    end
    frame_cur = step ? frame_nxt : frame_q;
    sf_begin  = step && (frame_nxt == FW'(1));
  end

  always_comb begin
    sel = SEL_NONE;
    if (frame_cur == FW'(SF_D4 / 2)) begin
      sel = SEL_A;
    end else if (frame_cur == FW'(SF_D4)) begin
      sel = SEL_B;
    end else if (esf_mode && (frame_cur == FW'(SF_D4 + SF_D4 / 2))) begin
      sel = SEL_C;
    end else if (esf_mode && (frame_cur == FW'(SF_ESF))) begin
      sel = SEL_D;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
    end else if (step) begin
      frame_q <= frame_nxt;
    end
  end

  // R3: resync forces frame 1
  a_r3_resync: assert property (@(posedge clk) disable iff (!rst_n)
    step && resync |=> frame_q == FW'(1));
  // R3: wrap after the last frame of the current format
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    step && !resync && (frame_q == sf_len) |=> frame_q == FW'(1));
  // R3: counter only moves on a frame start
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(frame_q));
  // R6: no C or D selection in short mode
  a_r6_no_cd: assert property (@(posedge clk) disable iff (!rst_n)
    !esf_mode |-> (sel != SEL_C) && (sel != SEL_D));
endmodule

// File: rtl/t1_rbs_sig_store.sv
module t1_rbs_sig_store
  import t1_rbs_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int CHW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CHW-1:0]   wr_chan,
  input  logic [SIG_W-1:0] wr_sig,
  input  logic             commit,
  input  logic [CHW-1:0]   rd_chan,
  output logic [SIG_W-1:0] rd_sig
);
  logic [NUM_CH-1:0][SIG_W-1:0] pend_q, pend_d, act_q, act_d;
  logic [NUM_CH-1:0]            wr_hit;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    assign wr_hit[g] = wr_en && (wr_chan == CHW'(g));
  end

  always_comb begin
    pend_d = pend_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (wr_hit[i]) pend_d[i] = wr_sig;
    end
    act_d = commit ? pend_q : act_q;
  end

  always_comb begin
    rd_sig = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_chan == CHW'(i)) rd_sig = act_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (wr_en)  pend_q <= pend_d;
      if (commit) act_q  <= act_d;
    end
  end

  // R9: active words change only at a superframe start
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_q));
  // R9: at the boundary, the pending words go into service
  a_r9_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> act_q == $past(pend_q));
  // R9: out-of-range writes leave the pending words untouched
  a_r9_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_chan >= CHW'(NUM_CH)) |=> $stable(pend_q));
endmodule

// File: rtl/t1_rbs_insert.sv
module t1_rbs_insert
  import t1_rbs_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int CHW    = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [CHW-1:0]    in_chan,
  input  logic              rb_en,
  input  logic [NUM_CH-1:0] clear_mask,
  input  sig_sel_e          sel,
  input  logic [SIG_W-1:0]  sig,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte
);
  logic              ch_known, clr_hit, rob, sbit;
  logic [BYTE_W-1:0] byte_d, byte_q;
  logic              vld_q;

  always_comb begin
    ch_known = 1'b0;
    clr_hit  = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (in_chan == CHW'(i)) begin
        ch_known = 1'b1;
        clr_hit  = clear_mask[i];
      end
    end
  end

  always_comb begin
    unique case (sel)
      SEL_A:   sbit = sig[SIG_W-1];
      SEL_B:   sbit = sig[SIG_W-2];
      SEL_C:   sbit = sig[SIG_W-3];
      SEL_D:   sbit = sig[SIG_W-4];
      default: sbit = 1'b0;
    endcase
    rob    = rb_en && ch_known && !clr_hit && (sel != SEL_NONE);
    byte_d = rob ? {in_byte[BYTE_W-1:1], sbit} : in_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) byte_q <= byte_d;
    end
  end

  assign out_valid = vld_q;
  assign out_byte  = byte_q;

  // R1: one-cycle latency of the valid flag
  a_r1_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2: only the last bit may change
  a_r2_upper: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_byte[BYTE_W-1:1] == $past(in_byte[BYTE_W-1:1]));
  // R7: global disable means transparent
  a_r7_off: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !rb_en |=> out_byte == $past(in_byte));
  // R10: non-signaling frames are transparent
  a_r10_plain: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (sel == SEL_NONE) |=> out_byte == $past(in_byte));
endmodule

// File: rtl/t1_rbs_inserter.sv
module t1_rbs_inserter
  import t1_rbs_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int SF_D4  = 12,
  parameter int BYTE_W = 8,
  localparam int CHW   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rb_en,
  input  logic              cfg_esf,
  input  logic [NUM_CH-1:0] cfg_clear,
  input  logic              wr_en,
  input  logic [CHW-1:0]    wr_chan,
  input  logic [SIG_W-1:0]  wr_sig,
  input  logic              in_valid,
  input  logic [CHW-1:0]    in_chan,
  input  logic              in_frame_start,
  input  logic              in_sf_start,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte
);
  sig_sel_e         sel;
  logic             sf_begin, step;
  logic [SIG_W-1:0] cur_sig;

  assign step = in_valid && in_frame_start;

  t1_rbs_frame_ctr #(.SF_D4(SF_D4)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .esf_mode (cfg_esf),
    .step     (step),
    .resync   (in_sf_start),
    .sel      (sel),
    .sf_begin (sf_begin)
  );

  t1_rbs_sig_store #(.NUM_CH(NUM_CH), .CHW(CHW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_chan (wr_chan),
    .wr_sig  (wr_sig),
    .commit  (sf_begin),
    .rd_chan (in_chan),
    .rd_sig  (cur_sig)
  );

  t1_rbs_insert #(.NUM_CH(NUM_CH), .CHW(CHW), .BYTE_W(BYTE_W)) u_ins (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .in_chan    (in_chan),
    .rb_en      (cfg_rb_en),
    .clear_mask (cfg_clear),
    .sel        (sel),
    .sig        (cur_sig),
    .out_valid  (out_valid),
    .out_byte   (out_byte)
  );

  // R8: a clear channel is transparent
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_chan < CHW'(NUM_CH)) && cfg_clear[in_chan] |=> out_byte == $past(in_byte));
endmodule

// File: tb/t1_rbs_inserter_tb.sv
module t1_rbs_inserter_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_rb_en = 1'b0, cfg_esf = 1'b0;
  logic [23:0] cfg_clear = '0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_chan = '0;
  logic [3:0] wr_sig = '0;
  logic       in_valid = 1'b0, in_frame_start = 1'b0, in_sf_start = 1'b0;
  logic [4:0] in_chan = '0;
  logic [7:0] in_byte = '0;
  logic       out_valid;
  logic [7:0] out_byte;

  int checks = 0, errors = 0, fr = 0, seed = 0;
  logic [3:0] pend [24];
  logic [3:0] act  [24];

  always #(CLK_P/2) clk = ~clk;

  t1_rbs_inserter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_rb_en(cfg_rb_en), .cfg_esf(cfg_esf),
    .cfg_clear(cfg_clear), .wr_en(wr_en), .wr_chan(wr_chan), .wr_sig(wr_sig),
    .in_valid(in_valid), .in_chan(in_chan), .in_frame_start(in_frame_start),
    .in_sf_start(in_sf_start), .in_byte(in_byte), .out_valid(out_valid),
    .out_byte(out_byte)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s frame=%0d got %h expected %h", req, fr, got, exp);
    end
  endtask

  task automatic push(input string ctx, input logic [4:0] ch, input logic fs, input logic sf);
    logic [7:0] b, exp;
    string req;
    int len;
    b = 8'(seed * 29 + 8'h3C);
    seed++;
    len = cfg_esf ? 24 : 12;
    if (fs) begin
      fr = sf ? 1 : ((fr >= len) ? 1 : fr + 1);
      if (fr == 1) for (int i = 0; i < 24; i++) act[i] = pend[i];
    end
    exp = b;
    req = "R10";
    if (!cfg_rb_en) req = "R7";
    else if (ch >= 24 || cfg_clear[ch]) req = "R8";
    else if (fr == 6)                   begin req = "R4"; exp[0] = act[ch][3]; end
    else if (fr == 12)                  begin req = "R4"; exp[0] = act[ch][2]; end
    else if (cfg_esf && fr == 18)       begin req = "R5"; exp[0] = act[ch][1]; end
    else if (cfg_esf && fr == 24)       begin req = "R5"; exp[0] = act[ch][0]; end
    @(negedge clk);
    in_valid = 1'b1; in_chan = ch; in_frame_start = fs; in_sf_start = sf; in_byte = b;
    @(posedge clk); #1;
    check({ctx, "/R1"}, {7'd0, out_valid}, 8'd1);
    if (out_byte[7:1] !== exp[7:1]) req = "R2";
    check({ctx, "/", req}, out_byte, exp);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_frame_start = 1'b0; in_sf_start = 1'b0;
  endtask

  task automatic send_frames(input string ctx, input int n, input logic first_sf);
    for (int f = 0; f < n; f++)
      for (int c = 0; c < 24; c++)
        push(ctx, 5'(c), c == 0, first_sf && f == 0 && c == 0);
    idle();
  endtask

  task automatic write_sig(input logic [4:0] ch, input logic [3:0] v);
    @(negedge clk);
    in_valid = 1'b0; wr_en = 1'b1; wr_chan = ch; wr_sig = v;
    if (ch < 24) pend[ch] = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 24; i++) begin pend[i] = '0; act[i] = '0; end
    #(CLK_P * 3);
    check("R1 reset valid", {7'd0, out_valid}, 8'd0);
    check("R1 reset byte", out_byte, 8'd0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_latency();
    push("R1", 5'd3, 1'b0, 1'b0);
    idle();
    @(posedge clk); #1;
    check("R1 idle valid", {7'd0, out_valid}, 8'd0);
  endtask

  task automatic t_d4();
    cfg_esf = 1'b0; cfg_rb_en = 1'b1; cfg_clear = '0;
    for (int c = 0; c < 24; c++) write_sig(5'(c), 4'(c * 5 + 3));
    send_frames("R4 d4", 12, 1'b1);
    send_frames("R6 d4 wrap", 18, 1'b0);   // R6: frames 13..18 become 1..6
  endtask

  task automatic t_esf();
    cfg_esf = 1'b1;
    for (int c = 0; c < 24; c++) write_sig(5'(c), 4'(c * 11 + 6));
    send_frames("R5 esf", 48, 1'b1);
  endtask

  task automatic t_commit();
    send_frames("R9 pre", 8, 1'b1);
    write_sig(5'd2, ~act[2]);
    write_sig(5'd9, ~act[9]);
    write_sig(5'd30, 4'hF);                // R9: out of range, ignored
    send_frames("R9 old", 16, 1'b0);
    send_frames("R9 new", 24, 1'b0);
  endtask

  task automatic t_resync();
    // R3: a resync mid-superframe restarts at frame 1
    send_frames("R3 a", 3, 1'b1);
    send_frames("R3 b", 12, 1'b1);
  endtask

  task automatic t_rb_off();
    cfg_rb_en = 1'b0;
    send_frames("R7", 24, 1'b1);
    cfg_rb_en = 1'b1;
  endtask

  task automatic t_clear();
    cfg_clear = 24'h00F0A5;
    send_frames("R8", 24, 1'b1);
    push("R8 chan24", 5'd24, 1'b0, 1'b0);
    idle();
    cfg_clear = '0;
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_d4();
    t_esf();
    t_commit();
    t_resync();
    t_rb_off();
    t_clear();
    #(CLK_P * 2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule